// File: doc/BRIEF.md
# Four-Variable Two-Level Minimizer

This block minimizes a Boolean function of four variables into a sum of products. The caller presents the function as two 16-bit minterm masks: the ON-set (minterms that must be 1) and the don't-care set (minterms that may be either value). A one-cycle start pulse launches a run. The engine builds every cube of the four-variable space and marks the cubes that are prime implicants. It then flags the essential primes and completes a cover of the ON-set that uses the fewest product terms. Three 81-bit cube masks (primes, essentials, cover) and a done flag return the result.

The work runs as a sequence of passes under one state machine. In `IDLE` an accepted start (transition GO) latches both masks and enters `IMPL`, which tests one cube per cycle for being an implicant. `PRIME` tests one cube per cycle for maximality. `ESS` visits one minterm per cycle and flags any prime that is the only prime covering an ON minterm. `CAND` lists, one cube per cycle, the non-essential primes that still cover an uncovered ON minterm. From `CAND`, the transition SKIP goes straight to `DONE` when nothing remains uncovered. Otherwise the transition SEEK enters `SEARCH`, which tests one subset of the candidates per cycle in increasing size and moves to `DONE` on the first subset that covers. From `DONE`, a new start (transition RESTART) begins another run.

Top module: `sop4_minimizer`

## Requirements
- R1: Cube index c = t0 + 3*t1 + 9*t2 + 27*t3, where variable v is bit v of a minterm number and its trit t_v is 0 (variable low), 1 (variable high) or 2 (variable absent). Bit c of each result vector refers to cube c, and cube 80 is the cube with no literals.
- R2: A cube is reported prime exactly when all of its minterms lie in the ON-set or the don't-care set and no larger such cube contains it.
- R3: Cubes join minterms that sit on opposite map edges. For example, an ON-set of minterms 0, 2, 8 and 10 yields cube 60 as its only prime, its only essential and its whole cover.
- R4: A prime is flagged essential exactly when it is the only prime covering some ON minterm. Covering a don't-care minterm never makes a prime essential.
- R5: The cover contains every essential prime, contains only primes, and covers every ON minterm.
- R6: Beyond the essentials, the cover adds the smallest possible number of primes, chosen only from non-essential primes that cover an ON minterm left uncovered by the essentials. When several sets of that size qualify, the set chosen is the one with the smallest sum of 2^r, where r is each prime's rank (0 = lowest cube index) among those candidates.
- R7: A start pulse taken in IDLE or DONE raises busy on the next cycle and lowers done. A start pulse while busy is ignored, and the run continues on the masks that were latched when it was accepted.
- R8: After done rises, done and all three result vectors stay unchanged, whatever the mask inputs do, until the next accepted start.
- R9: An empty ON-set gives an empty essential set and an empty cover. When the ON-set and don't-care set together hold all 16 minterms, cube 80 is the only prime.
- R10: After reset, busy and done are low and all three result vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured in IDLE and DONE |
| on_i | input | 16 | ON-set minterm mask |
| dc_i | input | 16 | Don't-care minterm mask |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Results valid and held |
| prime_o | output | 81 | Prime implicant flag per cube index |
| ess_o | output | 81 | Essential prime flag per cube index |
| cover_o | output | 81 | Selected cover flag per cube index |

## Verification
Busy is due on the first edge after the accepted start. The results are due together when done rises. This happens 259 edges after the start edge when the essentials already cover the ON-set, plus one edge for each subset tried when a search is needed. Because the search length depends on the function, the bench does not count to a fixed edge. It samples on falling edges until done is seen, then compares all three vectors against a brute-force model of primes, essentials and the ranked smallest cover. Hold behaviour is checked by sampling again after the inputs change and after a start pulse sent mid-run.

// File: rtl/sop4_pkg.sv
package sop4_pkg;

    localparam int NV  = 4;
    localparam int NM  = 1 << NV;
    localparam int NC  = 3 ** NV;
    localparam int CIW = $clog2(NC);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IMPL,
        ST_PRIME,
        ST_ESS,
        ST_CAND,
        ST_SEARCH,
        ST_DONE
    } state_t;

    // Minterm set of cube c: trit per variable, 2 means the variable is absent.
    function automatic logic [NM-1:0] cube_cover(input int c);
        logic [NM-1:0] r;
        int t;
        int tr;
        logic ok;
        r = '0;
        for (int m = 0; m < NM; m++) begin
            ok = 1'b1;
            t  = c;
            for (int v = 0; v < NV; v++) begin
                tr = t % 3;
                t  = t / 3;
                if (tr != 2 && tr != ((m >> v) & 1)) ok = 1'b0;
            end
            r[m] = ok;
        end
        return r;
    endfunction

endpackage

// File: rtl/sop4_cube_rom.sv
module sop4_cube_rom
    import sop4_pkg::*;
(
    output logic [NM-1:0] cmask_o [NC]
);
    for (genvar c = 0; c < NC; c++) begin : g_cube
        assign cmask_o[c] = cube_cover(c);
    end
endmodule

// File: rtl/sop4_subset_step.sv
module sop4_subset_step #(
    parameter int W  = 33,
    parameter int NW = 6
) (
    input  logic [W-1:0]  cur_i,
    input  logic [NW-1:0] n_i,
    output logic [W-1:0]  nxt_o
);
    logic [W-1:0] lsb;
    logic [W-1:0] ripple;
    logic [W-1:0] spread;
    logic [W-1:0] gosper;
    logic [W-1:0] wider;
    int           tz;
    int           k;

    always_comb begin
        tz = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cur_i[i]) tz = i;
        end
        k      = $countones(cur_i);
        lsb    = cur_i & (~cur_i + W'(1));
        ripple = cur_i + lsb;
        spread = ((ripple ^ cur_i) >> 2) >> tz;
        gosper = ripple | spread;
        wider  = (W'(1) << (k + 1)) - W'(1);
        nxt_o  = ((gosper >> n_i) != '0) ? wider : gosper;
    end
endmodule

// File: rtl/sop4_minimizer.sv
module sop4_minimizer
    import sop4_pkg::*;
#(
    parameter int MAXC = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [15:0]   on_i,
    input  logic [15:0]   dc_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [80:0]   prime_o,
    output logic [80:0]   ess_o,
    output logic [80:0]   cover_o
);
    localparam int W  = MAXC + 1;
    localparam int NW = $clog2(MAXC + 1);
    localparam int PW = $clog2(MAXC);

    state_t              state, state_nx;
    logic [NM-1:0]       on_q, dc_q;
    logic [CIW-1:0]      idx;
    logic [NV-1:0]       mt;
    logic [NC-1:0]       impl_q, prime_q, ess_q, cover_q;
    logic [CIW-1:0]      cand_idx [MAXC];
    logic [NM-1:0]       cand_msk [MAXC];
    logic [NW-1:0]       ncand;
    logic [W-1:0]        subset, subset_nx;
    logic [NM-1:0]       cmask [NC];

    logic [NM-1:0]       cur_mask, ess_cov, rem, sub_cov;
    logic [NC-1:0]       mvec, pick;
    logic                is_impl, has_bigger, single, cand_ok, hit, accept, last_idx;

    sop4_cube_rom u_rom (.cmask_o(cmask));

    sop4_subset_step #(.W(W), .NW(NW)) u_step (
        .cur_i (subset),
        .n_i   (ncand),
        .nxt_o (subset_nx)
    );

    always_comb begin
        cur_mask = cmask[idx];
        is_impl  = (cur_mask & ~(on_q | dc_q)) == '0;
        last_idx = (idx == CIW'(NC - 1));
        has_bigger = 1'b0;
        ess_cov    = '0;
        for (int j = 0; j < NC; j++) begin
            if (impl_q[j] && (CIW'(j) != idx) && ((cmask[j] & cur_mask) == cur_mask))
                has_bigger = 1'b1;
            mvec[j] = prime_q[j] & cmask[j][mt];
            if (ess_q[j]) ess_cov = ess_cov | cmask[j];
        end
        single  = on_q[mt] && ($countones(mvec) == 1);
        rem     = on_q & ~ess_cov;
        cand_ok = prime_q[idx] && !ess_q[idx] && ((cur_mask & rem) != '0);
        sub_cov = '0;
        pick    = '0;
        for (int p = 0; p < MAXC; p++) begin
            if (subset[p]) begin
                sub_cov        = sub_cov | cand_msk[p];
                pick[cand_idx[p]] = 1'b1;
            end
        end
        hit    = (sub_cov & rem) == rem;
        accept = start_i && (state == ST_IDLE || state == ST_DONE);
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= ST_IDLE;
        else         state <= state_nx;
    end

    // Transitions: GO, RESTART, SCAN ends, SKIP, SEEK, FOUND
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = ST_IMPL;
            ST_IMPL:   if (last_idx) state_nx = ST_PRIME;
            ST_PRIME:  if (last_idx) state_nx = ST_ESS;
            ST_ESS:    if (mt == NV'(NM - 1)) state_nx = ST_CAND;
            ST_CAND:   if (last_idx) state_nx = (rem == '0) ? ST_DONE : ST_SEARCH;
            ST_SEARCH: if (hit) state_nx = ST_DONE;
            ST_DONE:   if (start_i) state_nx = ST_IMPL;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            on_q    <= '0;
            dc_q    <= '0;
            idx     <= '0;
            mt      <= '0;
            impl_q  <= '0;
            prime_q <= '0;
            ess_q   <= '0;
            cover_q <= '0;
            ncand   <= '0;
            subset  <= '0;
            for (int p = 0; p < MAXC; p++) begin
                cand_idx[p] <= '0;
                cand_msk[p] <= '0;
            end
        end else if (accept) begin
            on_q    <= on_i;
            dc_q    <= dc_i;
            idx     <= '0;
            mt      <= '0;
            impl_q  <= '0;
            prime_q <= '0;
            ess_q   <= '0;
            cover_q <= '0;
            ncand   <= '0;
            subset  <= W'(1);
        end else begin
            case (state)
                ST_IMPL: begin
                    impl_q[idx] <= is_impl;
                    idx         <= last_idx ? '0 : idx + CIW'(1);
                end
                ST_PRIME: begin
                    prime_q[idx] <= impl_q[idx] && !has_bigger;
                    idx          <= last_idx ? '0 : idx + CIW'(1);
                end
                ST_ESS: begin
                    if (single) ess_q <= ess_q | mvec;
                    mt <= mt + NV'(1);
                end
                ST_CAND: begin
                    if (cand_ok && ncand < NW'(MAXC)) begin
                        cand_idx[ncand[PW-1:0]] <= idx;
                        cand_msk[ncand[PW-1:0]] <= cur_mask;
                        ncand                   <= ncand + NW'(1);
                    end
                    if (last_idx) begin
                        idx <= '0;
                        if (rem == '0) cover_q <= ess_q;
                    end else begin
                        idx <= idx + CIW'(1);
                    end
                end
                ST_SEARCH: begin
                    if (hit) cover_q <= ess_q | pick;
                    else     subset  <= subset_nx;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o  = (state != ST_IDLE) && (state != ST_DONE);
        done_o  = (state == ST_DONE);
        prime_o = prime_q;
        ess_o   = ess_q;
        cover_o = cover_q;
    end
endmodule

// File: rtl/sop4_min_checker.sv
module sop4_min_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [80:0] prime_o,
    input logic [80:0] ess_o,
    input logic [80:0] cover_o
);
    a_r8_hold_results: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(prime_o) && $stable(ess_o) && $stable(cover_o)));

    a_r5_ess_in_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((ess_o & ~cover_o) == '0));

    a_r5_cover_of_primes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((cover_o & ~prime_o) == '0));

    a_r4_ess_are_prime: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((ess_o & ~prime_o) == '0));

    a_r7_accept_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (busy_o && !done_o));
endmodule

bind sop4_minimizer sop4_min_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .prime_o (prime_o),
    .ess_o   (ess_o),
    .cover_o (cover_o)
);

// File: tb/tb_sop4_minimizer.sv
`timescale 1ns/1ps
module tb_sop4_minimizer;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] on_i = '0;
    logic [15:0] dc_i = '0;
    logic        busy_o, done_o;
    logic [80:0] prime_o, ess_o, cover_o;

    int checks = 0;
    int errors = 0;
    bit aborted = 0;

    logic [80:0] e_prime, e_ess, e_cover;

    always #2 clk_i = ~clk_i;

    sop4_minimizer dut (.*);

    function automatic logic [15:0] tmask(input int c);
        logic [15:0] r = '0;
        for (int m = 0; m < 16; m++) begin
            int t = c;
            bit ok = 1;
            for (int v = 0; v < 4; v++) begin
                int d = t % 3;
                t = t / 3;
                if (d == 0 && m[v]) ok = 0;
                if (d == 1 && !m[v]) ok = 0;
            end
            r[m] = ok;
        end
        return r;
    endfunction

    task automatic model(input logic [15:0] on, input logic [15:0] dc);
        logic [80:0] imp = '0;
        logic [15:0] cov = '0, rem;
        int cl [64];
        int n = 0;
        longint best = -1;
        int bestk = 99;
        e_prime = '0; e_ess = '0; e_cover = '0;
        for (int c = 0; c < 81; c++) imp[c] = (tmask(c) & ~(on | dc)) == 0;
        for (int c = 0; c < 81; c++) begin
            bit mx = imp[c];
            for (int j = 0; j < 81; j++)
                if (j != c && imp[j] && ((tmask(c) & ~tmask(j)) == 0)) mx = 0;
            e_prime[c] = mx;
        end
        for (int m = 0; m < 16; m++) begin
            int cnt = 0, who = 0;
            if (!on[m]) continue;
            for (int c = 0; c < 81; c++)
                if (e_prime[c] && tmask(c)[m]) begin cnt++; who = c; end
            if (cnt == 1) e_ess[who] = 1;
        end
        for (int c = 0; c < 81; c++) if (e_ess[c]) cov |= tmask(c);
        rem = on & ~cov;
        for (int c = 0; c < 81; c++)
            if (e_prime[c] && !e_ess[c] && (tmask(c) & rem) != 0 && n < 64) begin cl[n] = c; n++; end
        e_cover = e_ess;
        if (rem != 0) begin
            for (longint s = 1; s < (longint'(1) << n); s++) begin
                logic [15:0] u = '0;
                int k = 0;
                for (int p = 0; p < n; p++) if (s[p]) begin u |= tmask(cl[p]); k++; end
                if ((u & rem) == rem && k < bestk) begin bestk = k; best = s; end
            end
            for (int p = 0; p < n; p++) if (best[p]) e_cover[cl[p]] = 1;
        end
    endtask

    task automatic chk(input string tag, input logic [80:0] act, input logic [80:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 100000) begin @(negedge clk_i); n++; end
        if (!done_o) begin
            errors++; checks++; aborted = 1;
            $display("FAIL R7 watchdog act=timeout exp=done");
        end
    endtask

    task automatic pulse(input logic [15:0] on, input logic [15:0] dc);
        on_i = on; dc_i = dc; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    // Runs one function; tag names the requirement being targeted.
    task automatic run_case(input logic [15:0] on, input logic [15:0] dc, input string tag, input bit poke);
        model(on, dc);
        pulse(on, dc);
        chk1({tag, " R7 busy after start"}, busy_o, 1'b1);
        chk1({tag, " R7 done low after start"}, done_o, 1'b0);
        if (poke) begin
            repeat (20) @(negedge clk_i);
            pulse(~on, 16'h0);   // R7: ignored while busy
        end
        wait_done();
        if (aborted) return;
        chk({tag, " R2 primes"}, prime_o, e_prime);
        chk({tag, " R4 essentials"}, ess_o, e_ess);
        chk({tag, " R5 R6 cover"}, cover_o, e_cover);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        // R10 reset state
        chk1("R10 busy", busy_o, 1'b0);
        chk1("R10 done", done_o, 1'b0);
        chk("R10 prime", prime_o, '0);
        chk("R10 cover", cover_o, '0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R3 corners: minterms 0,2,8,10 -> cube 60 alone
        run_case(16'h0505, 16'h0000, "R3", 0);
        if (!aborted) begin
            chk("R3 cube60 prime", prime_o, 81'd1 << 60);
            chk("R3 cube60 cover", cover_o, 81'd1 << 60);
        end
        // R9 empty ON-set
        if (!aborted) run_case(16'h0000, 16'h0000, "R9 empty", 0);
        if (!aborted) chk("R9 empty cover", cover_o, '0);
        // R9 all don't-care
        if (!aborted) run_case(16'h0000, 16'hFFFF, "R9 alldc", 0);
        if (!aborted) begin
            chk("R9 alldc prime", prime_o, 81'd1 << 80);
            chk("R9 alldc cover", cover_o, '0);
        end
        // R9 mixed full
        if (!aborted) run_case(16'hF0F0, 16'h0F0F, "R9 full", 0);
        if (!aborted) chk("R9 full prime", prime_o, 81'd1 << 80);
        // R6 cyclic function: six primes, no essentials, three terms
        if (!aborted) run_case(16'h00E7, 16'h0000, "R6 cyclic", 0);
        if (!aborted) chk1("R6 cyclic size", $countones(cover_o) == 3, 1'b1);
        // R4 four essentials, the fifth prime left out
        if (!aborted) run_case(16'hB8E2, 16'h0000, "R4 four", 0);
        if (!aborted) chk1("R4 four size", $countones(cover_o) == 4 && cover_o == ess_o, 1'b1);
        // R4 don't-care coverage must not create essentials
        if (!aborted) run_case(16'h0001, 16'h0006, "R4 dc", 0);
        // R7 start ignored while busy
        if (!aborted) run_case(16'h5A3C, 16'h0100, "R7 poke", 1);
        // R8 hold after done while inputs move
        if (!aborted) begin
            on_i = 16'h1234; dc_i = 16'h4321;
            repeat (25) @(negedge clk_i);
            chk1("R8 done held", done_o, 1'b1);
            chk("R8 prime held", prime_o, e_prime);
            chk("R8 cover held", cover_o, e_cover);
        end
        // R1 R2 R6 random functions
        for (int i = 0; i < 40 && !aborted; i++) begin
            logic [15:0] d = 16'($urandom) & 16'($urandom) & 16'($urandom);
            logic [15:0] o = 16'($urandom) & ~d;
            run_case(o, d, "R1 rand", (i % 7) == 3);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule